// File: doc/BRIEF.md
# Nearest-Rate Configuration Selector

This block answers two kinds of question about a fixed set of supported PLL output rates. Each supported rate is stored together with its input, feedback, output and band divider settings in a small constant table. A nearest-rate query walks the table and reports the supported rate with the smallest distance to the requested frequency. An exact-rate query looks for an entry whose rate equals the request. It returns that entry's packed PLL control word, or an error when no entry matches.

A two-bit table selector, taken when the request is accepted, picks the table to search. Code 0 is the general-purpose table of nineteen rates from 100 MHz to 1.6 GHz. Code 1 is the three-entry video table (297, 540 and 594 MHz). Codes 2 and 3 are unpopulated. The table is read one entry per clock, and the walk stops at the first entry whose rate is zero. Requests use a valid/ready handshake. Each accepted request produces exactly one response, marked by a single-cycle valid pulse that carries an error flag, a rate and a control word. The block does not write the control word to a PLL, and it does not wait for lock.

Top module: `nearest_rate_selector`

## Requirements
- R1: After reset, rspValid is 0 and reqReady is 1.
- R2: A request is taken in a cycle where reqValid and reqReady are both 1. reqReady is 0 in the cycle after acceptance. Every accepted request yields exactly one response, and rspValid is high for a single cycle.
- R3: A nearest query (reqKind 0) returns the rate and control word of the entry with the smallest distance to the request. Distance is the larger value minus the smaller value, taken unsigned, so requests near 0 or near 2^32-1 are handled without overflow.
- R4: When two entries are equally distant from the request, a nearest query keeps the entry found earlier in the table.
- R5: The walk stops at the first entry whose rate is zero. A nearest query on a table whose first entry is zero (selector codes 2 and 3) responds with rspError set.
- R6: An exact query (reqKind 1) whose rate matches an entry responds with that rate and a control word laid out as follows: input divider in bits 8:4, feedback divider in bits 15:9, output divider in bits 3:2, band in bits 21:20, and bits 1:0 (power-down and bypass) at 0.
- R7: An exact query that matches no entry, including a request rate of 0, responds with rspError set. In an error response, rspRate and rspCtrlWord are 0.
- R8: Selector code 0 picks the general table and code 1 picks the video table. The selector, kind and rate are captured at acceptance, so changes to these inputs during the walk have no effect on the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request |
| reqKind | input | 1 | 0 = nearest query, 1 = exact query |
| reqTable | input | 2 | Table selector |
| reqRate | input | 32 | Requested rate in Hz |
| rspValid | output | 1 | Single-cycle response strobe |
| rspError | output | 1 | Empty table or no exact match |
| rspRate | output | 32 | Selected rate in Hz |
| rspCtrlWord | output | 32 | Packed divider control word |

## Verification
The assertions check the following on every cycle:
- The table index stays inside the table.
- At most one kind of response is issued at a time.
- A replacement candidate is strictly closer than the one it displaces.
- Every successful response has the power-down and bypass bits clear and a non-zero rate.
- Error responses carry zero fields.
- Handshake busy and response pulse width are correct.

Only the bench's scenarios can show that the chosen entry really is the nearest one. The same holds for the earlier entry winning on equal distance, for exact matches and misses against each table, for the packed field positions, and for inputs changed mid-walk being ignored.

// File: rtl/rate_sel_pkg.sv
package rate_sel_pkg;

  localparam int RATE_W      = 32;
  localparam int WORD_W      = 32;
  localparam int IDIV_W      = 5;
  localparam int FBDIV_W     = 7;
  localparam int ODIV_W      = 2;
  localparam int BAND_W      = 2;
  localparam int IDIV_LSB    = 4;
  localparam int FBDIV_LSB   = 9;
  localparam int ODIV_LSB    = 2;
  localparam int BAND_LSB    = 20;
  localparam int TABLE_SEL_W = 2;

  typedef struct packed {
    logic [RATE_W-1:0]  rate;
    logic [IDIV_W-1:0]  idiv;
    logic [FBDIV_W-1:0] fbdiv;
    logic [ODIV_W-1:0]  odiv;
    logic [BAND_W-1:0]  band;
  } pll_entry_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic captureReq;
    logic advance;
    logic takeCand;
    logic firstCand;
    logic emitBest;
    logic emitMatch;
    logic emitError;
  } scan_strobe_t;

  function automatic pll_entry_t makeEntry(input logic [RATE_W-1:0] r,
                                           input int unsigned i,
                                           input int unsigned f,
                                           input int unsigned o);
    pll_entry_t e;
    e.rate  = r;
    e.idiv  = IDIV_W'(i);
    e.fbdiv = FBDIV_W'(f);
    e.odiv  = ODIV_W'(o);
    e.band  = '0;
    return e;
  endfunction

  // power-down (bit 0) and bypass (bit 1) are left clear
  function automatic logic [WORD_W-1:0] packWord(input pll_entry_t e);
    logic [WORD_W-1:0] w;
    w = '0;
    w[IDIV_LSB  +: IDIV_W]  = e.idiv;
    w[FBDIV_LSB +: FBDIV_W] = e.fbdiv;
    w[ODIV_LSB  +: ODIV_W]  = e.odiv;
    w[BAND_LSB  +: BAND_W]  = e.band;
    return w;
  endfunction

endpackage

// File: rtl/rate_sel_rom.sv
module rate_sel_rom
  import rate_sel_pkg::*;
#(
  parameter int DEPTH = 20
) (
  input  logic [TABLE_SEL_W-1:0]     tableSel,
  input  logic [$clog2(DEPTH)-1:0]   idx,
  output pll_entry_t                 entry
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  pll_entry_t rawEntry;

  always_comb begin
    rawEntry = '0;
    unique case (tableSel)
      2'd0: begin
        case (idx)
          IDX_W'(0):  rawEntry = makeEntry(32'd100000000,  0, 11, 3);
          IDX_W'(1):  rawEntry = makeEntry(32'd133000000,  0, 15, 3);
          IDX_W'(2):  rawEntry = makeEntry(32'd200000000,  1, 47, 3);
          IDX_W'(3):  rawEntry = makeEntry(32'd233000000,  1, 27, 2);
          IDX_W'(4):  rawEntry = makeEntry(32'd300000000,  1, 35, 2);
          IDX_W'(5):  rawEntry = makeEntry(32'd333000000,  1, 39, 2);
          IDX_W'(6):  rawEntry = makeEntry(32'd400000000,  1, 47, 2);
          IDX_W'(7):  rawEntry = makeEntry(32'd500000000,  0, 14, 1);
          IDX_W'(8):  rawEntry = makeEntry(32'd600000000,  0, 17, 1);
          IDX_W'(9):  rawEntry = makeEntry(32'd700000000,  0, 20, 1);
          IDX_W'(10): rawEntry = makeEntry(32'd800000000,  0, 23, 1);
          IDX_W'(11): rawEntry = makeEntry(32'd900000000,  1, 26, 0);
          IDX_W'(12): rawEntry = makeEntry(32'd1000000000, 1, 29, 0);
          IDX_W'(13): rawEntry = makeEntry(32'd1100000000, 1, 32, 0);
          IDX_W'(14): rawEntry = makeEntry(32'd1200000000, 1, 35, 0);
          IDX_W'(15): rawEntry = makeEntry(32'd1300000000, 1, 38, 0);
          IDX_W'(16): rawEntry = makeEntry(32'd1400000000, 1, 41, 0);
          IDX_W'(17): rawEntry = makeEntry(32'd1500000000, 1, 44, 0);
          IDX_W'(18): rawEntry = makeEntry(32'd1600000000, 1, 47, 0);
          default:    rawEntry = '0;
        endcase
      end
      2'd1: begin
        case (idx)
          IDX_W'(0): rawEntry = makeEntry(32'd297000000, 0, 21, 2);
          IDX_W'(1): rawEntry = makeEntry(32'd540000000, 0, 19, 1);
          IDX_W'(2): rawEntry = makeEntry(32'd594000000, 0, 21, 1);
          default:   rawEntry = '0;
        endcase
      end
      default: rawEntry = '0;
    endcase
  end

  // the final slot is always a terminator, whatever DEPTH is
  always_comb begin
    entry = rawEntry;
    if (idx >= LAST_IDX) entry = '0;
  end

endmodule

// File: rtl/rate_sel_ctrl.sv
module rate_sel_ctrl
  import rate_sel_pkg::*;
#(
  parameter int DEPTH = 20
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  output logic                     reqReady,
  input  logic                     reqKind,
  input  logic                     entryZero,
  input  logic                     exactHit,
  input  logic                     closer,
  output logic [$clog2(DEPTH)-1:0] idx,
  output scan_strobe_t             strb
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  typedef enum logic {ST_IDLE, ST_SCAN} state_t;

  state_t           state;
  logic             kindQ;
  logic [IDX_W-1:0] idxQ;
  logic             isFirst;
  logic             isLast;
  logic             anyEmit;

  assign idx      = idxQ;
  assign reqReady = (state == ST_IDLE);
  assign isFirst  = (idxQ == '0);
  assign isLast   = (idxQ == LAST_IDX);
  assign anyEmit  = strb.emitBest | strb.emitMatch | strb.emitError;

  always_comb begin
    strb = '0;
    unique case (state)
      ST_IDLE: strb.captureReq = reqValid;
      ST_SCAN: begin
        if (!kindQ) begin
          if (entryZero) begin
            if (isFirst) strb.emitError = 1'b1;
            else         strb.emitBest  = 1'b1;
          end else begin
            strb.takeCand  = isFirst | closer;
            strb.firstCand = isFirst;
            if (isLast) strb.emitBest = 1'b1;
            else        strb.advance  = 1'b1;
          end
        end else begin
          if (entryZero)     strb.emitError = 1'b1;
          else if (exactHit) strb.emitMatch = 1'b1;
          else if (isLast)   strb.emitError = 1'b1;
          else               strb.advance   = 1'b1;
        end
      end
      default: strb = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      kindQ <= 1'b0;
      idxQ  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (strb.captureReq) begin
            state <= ST_SCAN;
            kindQ <= reqKind;
            idxQ  <= '0;
          end
        end
        ST_SCAN: begin
          if (strb.advance) idxQ <= idxQ + 1'b1;
          if (anyEmit)      state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: the walk never leaves the table
  assert_idx_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    idxQ <= LAST_IDX);

  // R2: at most one kind of response per cycle
  assert_single_emit_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.emitBest, strb.emitMatch, strb.emitError}));

  // R2: busy right after acceptance
  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

endmodule

// File: rtl/rate_sel_datapath.sv
module rate_sel_datapath
  import rate_sel_pkg::*;
#(
  parameter int DEPTH = 20
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  scan_strobe_t             strb,
  input  logic [RATE_W-1:0]        reqRate,
  input  logic [TABLE_SEL_W-1:0]   reqTable,
  input  logic [$clog2(DEPTH)-1:0] idx,
  output logic                     entryZero,
  output logic                     exactHit,
  output logic                     closer,
  output logic                     rspValid,
  output logic                     rspError,
  output logic [RATE_W-1:0]        rspRate,
  output logic [WORD_W-1:0]        rspCtrlWord
);
  logic [RATE_W-1:0]      reqRateQ;
  logic [TABLE_SEL_W-1:0] tableQ;
  pll_entry_t             entry;
  logic [RATE_W-1:0]      candDist;
  logic [WORD_W-1:0]      candWord;
  logic [RATE_W-1:0]      bestRate;
  logic [WORD_W-1:0]      bestWord;
  logic [RATE_W-1:0]      bestDist;

  rate_sel_rom #(.DEPTH(DEPTH)) u_rom (
    .tableSel (tableQ),
    .idx      (idx),
    .entry    (entry)
  );

  // larger minus smaller keeps the distance unsigned
  assign candDist  = (entry.rate >= reqRateQ) ? (entry.rate - reqRateQ)
                                              : (reqRateQ - entry.rate);
  assign candWord  = packWord(entry);
  assign entryZero = (entry.rate == '0);
  assign exactHit  = (entry.rate == reqRateQ);
  assign closer    = (candDist < bestDist);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqRateQ <= '0;
      tableQ   <= '0;
      bestRate <= '0;
      bestWord <= '0;
      bestDist <= '0;
    end else begin
      if (strb.captureReq) begin
        reqRateQ <= reqRate;
        tableQ   <= reqTable;
      end
      if (strb.takeCand) begin
        bestRate <= entry.rate;
        bestWord <= candWord;
        bestDist <= candDist;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspError    <= 1'b0;
      rspRate     <= '0;
      rspCtrlWord <= '0;
    end else begin
      rspValid <= strb.emitBest | strb.emitMatch | strb.emitError;
      if (strb.emitError) begin
        rspError    <= 1'b1;
        rspRate     <= '0;
        rspCtrlWord <= '0;
      end else if (strb.emitMatch || (strb.emitBest && strb.takeCand)) begin
        rspError    <= 1'b0;
        rspRate     <= entry.rate;
        rspCtrlWord <= candWord;
      end else if (strb.emitBest) begin
        rspError    <= 1'b0;
        rspRate     <= bestRate;
        rspCtrlWord <= bestWord;
      end
    end
  end

  // R3: a replacement is strictly closer than what it displaces
  assert_closer_replace_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.takeCand && !strb.firstCand) |=> (bestDist < $past(bestDist)));

  // R2: response strobe lasts one cycle
  assert_rsp_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R6: good responses keep power-down and bypass clear
  assert_ctrl_bits_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspError) |-> (rspCtrlWord[1:0] == 2'b00 && rspRate != '0));

  // R7: error responses carry zero fields
  assert_error_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspError) |-> (rspRate == '0 && rspCtrlWord == '0));

endmodule

// File: rtl/nearest_rate_selector.sv
module nearest_rate_selector
  import rate_sel_pkg::*;
#(
  parameter int DEPTH = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        reqKind,
  input  logic [1:0]  reqTable,
  input  logic [31:0] reqRate,
  output logic        rspValid,
  output logic        rspError,
  output logic [31:0] rspRate,
  output logic [31:0] rspCtrlWord
);
  localparam int IDX_W = $clog2(DEPTH);

  scan_strobe_t     strb;
  logic [IDX_W-1:0] idx;
  logic             entryZero;
  logic             exactHit;
  logic             closer;

  rate_sel_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqReady  (reqReady),
    .reqKind   (reqKind),
    .entryZero (entryZero),
    .exactHit  (exactHit),
    .closer    (closer),
    .idx       (idx),
    .strb      (strb)
  );

  rate_sel_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .reqRate     (reqRate),
    .reqTable    (reqTable),
    .idx         (idx),
    .entryZero   (entryZero),
    .exactHit    (exactHit),
    .closer      (closer),
    .rspValid    (rspValid),
    .rspError    (rspError),
    .rspRate     (rspRate),
    .rspCtrlWord (rspCtrlWord)
  );

endmodule

// File: tb/nearest_rate_selector_bench.sv
module nearest_rate_selector_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqKind = 1'b0;
  logic [1:0]  reqTable = 2'd0;
  logic [31:0] reqRate = '0;
  logic        rspValid;
  logic        rspError;
  logic [31:0] rspRate;
  logic [31:0] rspCtrlWord;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct {
    logic        err;
    logic [31:0] rate;
    logic [31:0] word;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  always #2.5 clk = ~clk;

  nearest_rate_selector u_nearest_rate_selector (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqKind(reqKind), .reqTable(reqTable), .reqRate(reqRate),
    .rspValid(rspValid), .rspError(rspError), .rspRate(rspRate),
    .rspCtrlWord(rspCtrlWord));

  // bench-side model tables
  function automatic int tblCount(input int t);
    if (t == 0) return 19;
    if (t == 1) return 3;
    return 0;
  endfunction

  function automatic logic [31:0] modelRate(input int t, input int i);
    int unsigned genMhz[19] = '{100,133,200,233,300,333,400,500,600,700,800,
                                900,1000,1100,1200,1300,1400,1500,1600};
    int unsigned vidMhz[3] = '{297,540,594};
    if (t == 0) return genMhz[i] * 32'd1000000;
    return vidMhz[i] * 32'd1000000;
  endfunction

  function automatic logic [31:0] modelWord(input int t, input int i);
    int genI[19] = '{0,0,1,1,1,1,1,0,0,0,0,1,1,1,1,1,1,1,1};
    int genF[19] = '{11,15,47,27,35,39,47,14,17,20,23,26,29,32,35,38,41,44,47};
    int genO[19] = '{3,3,3,2,2,2,2,1,1,1,1,0,0,0,0,0,0,0,0};
    int vidI[3] = '{0,0,0};
    int vidF[3] = '{21,19,21};
    int vidO[3] = '{2,1,1};
    if (t == 0) return (32'(genI[i]) << 4) | (32'(genF[i]) << 9) | (32'(genO[i]) << 2);
    return (32'(vidI[i]) << 4) | (32'(vidF[i]) << 9) | (32'(vidO[i]) << 2);
  endfunction

  function automatic exp_t model(input logic kind, input int t, input logic [31:0] r,
                                 input string tag);
    exp_t e;
    logic [31:0] best, d, bd;
    int bi;
    e.err = 1'b1; e.rate = '0; e.word = '0; e.tag = tag;
    if (tblCount(t) == 0) return e;
    if (!kind) begin
      bi = 0;
      best = modelRate(t, 0);
      bd = (best >= r) ? best - r : r - best;
      for (int i = 1; i < tblCount(t); i++) begin
        d = (modelRate(t, i) >= r) ? modelRate(t, i) - r : r - modelRate(t, i);
        if (d < bd) begin bd = d; bi = i; end
      end
      e.err = 1'b0; e.rate = modelRate(t, bi); e.word = modelWord(t, bi);
    end else begin
      for (int i = 0; i < tblCount(t); i++)
        if (r != 0 && modelRate(t, i) == r) begin
          e.err = 1'b0; e.rate = r; e.word = modelWord(t, i);
        end
    end
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  // monitor: pop expected results as responses appear
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2", "unexpected response, actual rspValid=1 expected 0");
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(rspError == e.err && rspRate == e.rate && rspCtrlWord == e.word, e.tag,
              $sformatf("actual err=%0b rate=%0d word=%h expected err=%0b rate=%0d word=%h",
                        rspError, rspRate, rspCtrlWord, e.err, e.rate, e.word));
      end
    end
  end

  task automatic send(input logic kind, input int t, input logic [31:0] r, input string tag);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    expQ.push_back(model(kind, t, r, tag));
    reqValid = 1'b1; reqKind = kind; reqTable = 2'(t); reqRate = r;
    @(negedge clk);
    // R8: scramble inputs during the walk
    reqValid = 1'b0; reqKind = ~kind; reqTable = ~2'(t); reqRate = 32'hDEAD_BEEF;
    check(!reqReady, "R2", $sformatf("actual reqReady=%0b expected 0 after accept", reqReady));
    while (expQ.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(rspValid == 1'b0 && reqReady == 1'b1, "R1",
          $sformatf("actual rspValid=%0b reqReady=%0b expected 0/1", rspValid, reqReady));
    rstN = 1'b1;
    send(1'b0, 0, 32'd0,          "R3 low end");
    send(1'b0, 0, 32'hFFFF_FFFF,  "R3 top end no overflow");
    send(1'b0, 0, 32'd710000000,  "R3 mid");
    send(1'b0, 0, 32'd116500000,  "R4 tie 100/133");
    send(1'b0, 0, 32'd450000000,  "R4 tie 400/500");
    send(1'b0, 1, 32'd418500000,  "R4 R8 video tie 297/540");
    send(1'b0, 1, 32'd567000000,  "R4 R8 video tie 540/594");
    send(1'b0, 1, 32'd1000000000, "R3 R8 video high");
    send(1'b0, 2, 32'd500000000,  "R5 empty table 2");
    send(1'b0, 3, 32'd500000000,  "R5 empty table 3");
    send(1'b1, 0, 32'd100000000,  "R6 exact 100M");
    send(1'b1, 0, 32'd1600000000, "R6 exact 1.6G");
    send(1'b1, 1, 32'd540000000,  "R6 R8 exact video 540M");
    send(1'b1, 0, 32'd540000000,  "R7 R8 miss in general");
    send(1'b1, 1, 32'd0,          "R7 zero rate");
    send(1'b1, 2, 32'd297000000,  "R7 empty table");
    repeat (5) @(negedge clk);
    check(expQ.size() == 0, "R2", $sformatf("actual pending=%0d expected 0", expQ.size()));
    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (done || cycles > 100000) begin
      if (!done) check(1'b0, "watchdog", "actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule